// File: doc/BRIEF.md
# Banked Processor Register File

This block stores the architectural integer state of a small 32-bit core. It holds sixteen general registers and an 8-bit flag register. Index values 0 to 7 select the data registers and 8 to 15 select the address registers. Index 15 is the stack pointer. That register has two physical copies: one serves user mode and one serves supervisor mode. The `supervisor` input decides which copy the normal read and write ports reach. A separate pair of ports always reaches the copy that is not active, so mode-switch code can save and restore it.

Two read ports are combinational. One write port carries a size code, and the size rules depend on the register class. A data register takes byte, word or longword writes, and a partial write keeps the untouched upper bits. An address register takes word writes, which it stores sign-extended, and longword writes. A write that breaks these rules is dropped and `err` is raised for one cycle. A flag port updates the five flags under a per-bit enable mask, so an instruction can change only the flags it defines.

Top module: `gpr_bank`

## Requirements
- R1: `rdSelA`/`rdSelB` values 0–7 return data registers 0–7 and values 8–15 return address registers 0–7, combinationally, on both ports independently.
- R2: Index 15 reads and writes the supervisor stack copy when `supervisor` is 1 and the user copy when it is 0; the other copy is unaffected.
- R3: `altSpRdData` always shows the inactive stack copy, and `altSpWrEn` writes `altSpWrData` as a longword into that inactive copy.
- R4: Size codes are 0 = byte, 1 = word and 2 = longword. A data-register write of size 0 changes bits 7:0 only, size 1 changes bits 15:0 only, and size 2 changes all 32 bits.
- R5: An address-register write of size 1 stores bits 15:0 sign-extended to 32 bits, and size 2 stores all 32 bits.
- R6: A write with size code 3, or with size 0 to an address register (index 8–15), changes no register, and `err` is 1 in the following cycle only. A legal write or no write leaves `err` at 0 in the next cycle.
- R7: `ccr` is laid out as X at bit 4, N at bit 3, Z at bit 2, V at bit 1 and C at bit 0. Bits 7:5 always read as zero.
- R8: When `flagWrEn` is 1, each flag whose `flagMask` bit is set takes the matching `flagData` bit on the next edge. Flags with a clear mask bit keep their value.
- R9: A read of a register in the same cycle as a write to it returns the value from before the write.
- R10: Reset (active-low `rstN`) clears all sixteen registers, both stack copies and all flags to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| supervisor | input | 1 | Selects the active stack copy (1 = supervisor) |
| rdSelA | input | 4 | Read port A register index |
| rdDataA | output | 32 | Read port A data |
| rdSelB | input | 4 | Read port B register index |
| rdDataB | output | 32 | Read port B data |
| wrEn | input | 1 | Write request |
| wrSel | input | 4 | Write register index |
| wrSize | input | 2 | Write size code (0 byte, 1 word, 2 long, 3 invalid) |
| wrData | input | 32 | Write data |
| altSpWrEn | input | 1 | Write to the inactive stack copy |
| altSpWrData | input | 32 | Data for the inactive stack copy |
| altSpRdData | output | 32 | Contents of the inactive stack copy |
| flagWrEn | input | 1 | Flag update request |
| flagMask | input | 5 | Per-flag update enable |
| flagData | input | 5 | New flag values |
| ccr | output | 8 | Flag register, bits 7:5 zero |
| err | output | 1 | Pulse for a rejected write |

## Verification
The bench targets partial writes over a full longword. A design that zero-filled or sign-extended data registers would lose the upper bits there. It also writes index 15 in both modes and reads it across mode flips. A wrongly banked stack pointer would leak one copy into the other, or the alternate port would show the active copy. Byte and invalid-size writes to address registers check that a rejected write really leaves the state intact and pulses `err` exactly once. Partial flag masks and same-cycle read-after-write catch a design that updates flags it should hold, or that forwards new data to the read port.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  // log2 of the number of registers in each class
  localparam int IDX_W = 3;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_BAD  = 2'd3
  } wsize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             dataWe;
    logic             addrWe;
    logic             spUsrWe;
    logic             spSupWe;
    logic             altUsrWe;
    logic             altSupWe;
    logic [IDX_W-1:0] idx;
    wsize_e           size;
  } wr_stb_t;
endpackage

// File: rtl/gpr_ctrl.sv
module gpr_ctrl
  import gpr_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           supervisor,
  input  logic           wrEn,
  input  logic [IDX_W:0] wrSel,
  input  wsize_e         wrSize,
  input  logic           altSpWrEn,
  output wr_stb_t        stb,
  output logic           err
);
  localparam logic [IDX_W-1:0] SP_IDX = {IDX_W{1'b1}};

  logic isAddr, isSp, illegal, okWr;

  always_comb begin
    isAddr  = wrSel[IDX_W];
    isSp    = isAddr && (wrSel[IDX_W-1:0] == SP_IDX);
    illegal = wrEn && ((wrSize == SZ_BAD) || (isAddr && wrSize == SZ_BYTE));
    okWr    = wrEn && !illegal;

    stb          = '0;
    stb.idx      = wrSel[IDX_W-1:0];
    stb.size     = wrSize;
    stb.dataWe   = okWr && !isAddr;
    stb.addrWe   = okWr && isAddr && !isSp;
    stb.spUsrWe  = okWr && isSp && !supervisor;
    stb.spSupWe  = okWr && isSp && supervisor;
    stb.altUsrWe = altSpWrEn && supervisor;
    stb.altSupWe = altSpWrEn && !supervisor;
  end

  always_ff @(posedge clk) begin
    if (!rstN) err <= 1'b0;
    else       err <= illegal;
  end

  // R6: an invalid size code must be flagged on the next cycle
  a_r6_bad_size_err: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSize == SZ_BAD) |=> err);

  // R6: a byte write to an address register is flagged too
  a_r6_addr_byte_err: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel[IDX_W] && wrSize == SZ_BYTE) |=> err);

  // R6: no write request means no error
  a_r6_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> !err);

  // R3: the main and alternate paths never hit the same stack copy
  a_r3_alt_distinct: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.spUsrWe && stb.altUsrWe) && !(stb.spSupWe && stb.altSupWe));
endmodule

// File: rtl/gpr_dpath.sv
module gpr_dpath
  import gpr_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int FLAG_W = 5,
  parameter int CCR_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              supervisor,
  input  wr_stb_t           stb,
  input  logic [XLEN-1:0]   wrData,
  input  logic [XLEN-1:0]   altData,
  input  logic [IDX_W:0]    rdSelA,
  input  logic [IDX_W:0]    rdSelB,
  input  logic              flagWrEn,
  input  logic [FLAG_W-1:0] flagMask,
  input  logic [FLAG_W-1:0] flagData,
  output logic [XLEN-1:0]   rdDataA,
  output logic [XLEN-1:0]   rdDataB,
  output logic [XLEN-1:0]   altRdData,
  output logic [CCR_W-1:0]  ccr
);
  localparam int NREG  = 1 << IDX_W;
  localparam int HALF  = XLEN / 2;
  localparam int BYTEW = 8;

  logic [XLEN-1:0]   dReg [NREG];
  logic [XLEN-1:0]   aReg [NREG-1];
  logic [XLEN-1:0]   spUsr, spSup, activeSp, addrVal;
  logic [XLEN-1:0]   view [2*NREG];
  logic [FLAG_W-1:0] flags;

  assign addrVal = (stb.size == SZ_WORD)
                 ? {{HALF{wrData[HALF-1]}}, wrData[HALF-1:0]} : wrData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) dReg[i] <= '0;
    end else if (stb.dataWe) begin
      for (int i = 0; i < NREG; i++) begin
        if (stb.idx == i[IDX_W-1:0]) begin
          case (stb.size)
            SZ_BYTE: dReg[i][BYTEW-1:0] <= wrData[BYTEW-1:0];
            SZ_WORD: dReg[i][HALF-1:0]  <= wrData[HALF-1:0];
            default: dReg[i]            <= wrData;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NREG-1; i++) aReg[i] <= '0;
    end else if (stb.addrWe) begin
      for (int i = 0; i < NREG-1; i++)
        if (stb.idx == i[IDX_W-1:0]) aReg[i] <= addrVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spUsr <= '0;
      spSup <= '0;
    end else begin
      if (stb.spUsrWe)       spUsr <= addrVal;
      else if (stb.altUsrWe) spUsr <= altData;
      if (stb.spSupWe)       spSup <= addrVal;
      else if (stb.altSupWe) spSup <= altData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         flags <= '0;
    else if (flagWrEn) flags <= (flags & ~flagMask) | (flagData & flagMask);
  end

  assign activeSp  = supervisor ? spSup : spUsr;
  assign altRdData = supervisor ? spUsr : spSup;
  assign ccr       = {{(CCR_W-FLAG_W){1'b0}}, flags};

  for (genvar g = 0; g < NREG; g++) begin : g_view
    assign view[g] = dReg[g];
    if (g == NREG-1) begin : g_sp
      assign view[NREG+g] = activeSp;
    end else begin : g_ar
      assign view[NREG+g] = aReg[g];
    end
  end

  assign rdDataA = view[rdSelA];
  assign rdDataB = view[rdSelB];

  // R8: flags outside the mask keep their value
  a_r8_mask_hold: assert property (@(posedge clk) disable iff (!rstN)
    flagWrEn |=> (((flags ^ $past(flags)) & ~$past(flagMask)) == '0));

  // R4: a byte write to a data register leaves the upper bits alone
  a_r4_byte_upper: assert property (@(posedge clk) disable iff (!rstN)
    (stb.dataWe && stb.size == SZ_BYTE)
      |=> dReg[$past(stb.idx)][XLEN-1:BYTEW] == $past(dReg[stb.idx][XLEN-1:BYTEW]));

  // R5: a word write to an address register is stored sign-extended
  a_r5_word_sext: assert property (@(posedge clk) disable iff (!rstN)
    (stb.addrWe && stb.size == SZ_WORD)
      |=> aReg[$past(stb.idx)][XLEN-1:HALF] == {HALF{aReg[$past(stb.idx)][HALF-1]}});

  // R2: the user copy holds unless one of its write paths fires
  a_r2_usp_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.spUsrWe || stb.altUsrWe) |=> $stable(spUsr));

  // R2: the supervisor copy holds unless one of its write paths fires
  a_r2_ssp_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.spSupWe || stb.altSupWe) |=> $stable(spSup));
endmodule

// File: rtl/gpr_bank.sv
module gpr_bank
  import gpr_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int FLAG_W = 5,
  parameter int CCR_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              supervisor,
  input  logic [IDX_W:0]    rdSelA,
  output logic [XLEN-1:0]   rdDataA,
  input  logic [IDX_W:0]    rdSelB,
  output logic [XLEN-1:0]   rdDataB,
  input  logic              wrEn,
  input  logic [IDX_W:0]    wrSel,
  input  logic [1:0]        wrSize,
  input  logic [XLEN-1:0]   wrData,
  input  logic              altSpWrEn,
  input  logic [XLEN-1:0]   altSpWrData,
  output logic [XLEN-1:0]   altSpRdData,
  input  logic              flagWrEn,
  input  logic [FLAG_W-1:0] flagMask,
  input  logic [FLAG_W-1:0] flagData,
  output logic [CCR_W-1:0]  ccr,
  output logic              err
);
  wr_stb_t stb;

  gpr_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .supervisor (supervisor),
    .wrEn       (wrEn),
    .wrSel      (wrSel),
    .wrSize     (wsize_e'(wrSize)),
    .altSpWrEn  (altSpWrEn),
    .stb        (stb),
    .err        (err)
  );

  gpr_dpath #(.XLEN(XLEN), .FLAG_W(FLAG_W), .CCR_W(CCR_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .supervisor (supervisor),
    .stb        (stb),
    .wrData     (wrData),
    .altData    (altSpWrData),
    .rdSelA     (rdSelA),
    .rdSelB     (rdSelB),
    .flagWrEn   (flagWrEn),
    .flagMask   (flagMask),
    .flagData   (flagData),
    .rdDataA    (rdDataA),
    .rdDataB    (rdDataB),
    .altRdData  (altSpRdData),
    .ccr        (ccr)
  );
endmodule

// File: tb/sim_gpr_bank.sv
module sim_gpr_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        supervisor = 1'b0;
  logic [3:0]  rdSelA = '0, rdSelB = '0, wrSel = '0;
  logic [31:0] rdDataA, rdDataB, wrData = '0, altSpWrData = '0, altSpRdData;
  logic        wrEn = 1'b0, altSpWrEn = 1'b0, flagWrEn = 1'b0;
  logic [1:0]  wrSize = '0;
  logic [4:0]  flagMask = '0, flagData = '0;
  logic [7:0]  ccr;
  logic        err;

  int tests = 0;
  int fails = 0;

  // reference state
  logic [31:0] mD [8];
  logic [31:0] mA [8];
  logic [31:0] mUsp, mSsp;
  logic [4:0]  mF;
  logic        expErr;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpr_bank u0 (
    .clk(clk), .rstN(rstN), .supervisor(supervisor),
    .rdSelA(rdSelA), .rdDataA(rdDataA), .rdSelB(rdSelB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrSel(wrSel), .wrSize(wrSize), .wrData(wrData),
    .altSpWrEn(altSpWrEn), .altSpWrData(altSpWrData), .altSpRdData(altSpRdData),
    .flagWrEn(flagWrEn), .flagMask(flagMask), .flagData(flagData),
    .ccr(ccr), .err(err)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mRead(input logic [3:0] s);
    if (!s[3])          return mD[s[2:0]];
    if (s[2:0] == 3'd7) return supervisor ? mSsp : mUsp;
    return mA[s[2:0]];
  endfunction

  task automatic modelClear();
    for (int i = 0; i < 8; i++) begin mD[i] = '0; mA[i] = '0; end
    mUsp = '0; mSsp = '0; mF = '0; expErr = 1'b0;
  endtask

  task automatic modelUpdate();
    logic        bad;
    logic [31:0] v;
    bad = wrEn && (wrSize == 2'd3 || (wrSel[3] && wrSize == 2'd0));
    if (wrEn && !bad) begin
      if (!wrSel[3]) begin
        case (wrSize)
          2'd0:    mD[wrSel[2:0]][7:0]  = wrData[7:0];
          2'd1:    mD[wrSel[2:0]][15:0] = wrData[15:0];
          default: mD[wrSel[2:0]]       = wrData;
        endcase
      end else begin
        v = (wrSize == 2'd1) ? {{16{wrData[15]}}, wrData[15:0]} : wrData;
        if (wrSel[2:0] == 3'd7) begin
          if (supervisor) mSsp = v; else mUsp = v;
        end else mA[wrSel[2:0]] = v;
      end
    end
    if (altSpWrEn) begin
      if (supervisor) mUsp = altSpWrData; else mSsp = altSpWrData;
    end
    if (flagWrEn) mF = (mF & ~flagMask) | (flagData & flagMask);
    expErr = bad;
  endtask

  // called at a falling edge with inputs already set
  task automatic step(input string tag);
    #1;
    chk(tag, "rdDataA", rdDataA, mRead(rdSelA));
    chk(tag, "rdDataB", rdDataB, mRead(rdSelB));
    chk(tag, "altSpRdData", altSpRdData, supervisor ? mUsp : mSsp);
    chk(tag, "ccr", {24'd0, ccr}, {27'd0, mF});
    chk(tag, "err", {31'd0, err}, {31'd0, expErr});
    @(posedge clk);
    modelUpdate();
    @(negedge clk);
  endtask

  task automatic idle();
    wrEn = 0; altSpWrEn = 0; flagWrEn = 0;
  endtask

  task automatic wr(input logic [3:0] s, input logic [1:0] sz, input logic [31:0] d);
    idle(); wrEn = 1; wrSel = s; wrSize = sz; wrData = d;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    modelClear();
    repeat (3) @(negedge clk);
    rstN = 1;
    // R10: every register and the flags come out of reset at zero
    for (int i = 0; i < 16; i++) begin
      rdSelA = 4'(i); #1;
      chk("R10", "reset read", rdDataA, 32'd0);
    end
    chk("R7", "reset ccr", {24'd0, ccr}, 32'd0);
    chk("R3", "reset alt", altSpRdData, 32'd0);
    @(negedge clk);

    // R4: partial data writes
    rdSelA = 4'd3; rdSelB = 4'd3;
    wr(4'd3, 2'd2, 32'hA5A5_A5A5); step("R4");
    wr(4'd3, 2'd0, 32'hFFFF_FF11); step("R4");
    wr(4'd3, 2'd1, 32'hFFFF_2222); step("R4");
    idle(); step("R4");
    chk("R4", "byte+word merge", rdDataA, 32'hA5A5_2222);

    // R5: word writes to address registers sign-extend
    rdSelA = 4'd10;
    wr(4'd10, 2'd1, 32'h0000_8001); step("R5");
    idle(); step("R5");
    chk("R5", "sext neg", rdDataA, 32'hFFFF_8001);
    wr(4'd10, 2'd1, 32'hABCD_7FFE); step("R5");
    wr(4'd9, 2'd2, 32'h1234_5678); step("R5");
    idle(); step("R5");
    chk("R5", "sext pos", rdDataA, 32'h0000_7FFE);

    // R6: rejected writes
    rdSelA = 4'd9;
    wr(4'd9, 2'd0, 32'hDEAD_BEEF); step("R6");
    wr(4'd3, 2'd3, 32'hDEAD_BEEF); step("R6");
    idle(); step("R6");
    chk("R6", "addr untouched", rdDataA, 32'h1234_5678);
    step("R6");

    // R2: stack banking through index 15
    rdSelA = 4'd15;
    supervisor = 0; wr(4'd15, 2'd2, 32'h0000_1000); step("R2");
    supervisor = 1; wr(4'd15, 2'd2, 32'h0000_2000); step("R2");
    idle(); step("R2");
    chk("R2", "sup copy", rdDataA, 32'h0000_2000);
    chk("R3", "alt shows user", altSpRdData, 32'h0000_1000);
    supervisor = 0; step("R2");
    chk("R2", "user copy", rdDataA, 32'h0000_1000);
    wr(4'd15, 2'd1, 32'h0000_F000); step("R2");

    // R3: write the inactive copy
    idle(); altSpWrEn = 1; altSpWrData = 32'h0000_3000; step("R3");
    idle(); supervisor = 1; step("R3");
    chk("R3", "alt into sup", rdDataA, 32'h0000_3000);

    // R9: read sees the old value during a write
    rdSelA = 4'd5;
    wr(4'd5, 2'd2, 32'h5555_0001); step("R9");
    wr(4'd5, 2'd2, 32'h5555_0002); #1;
    chk("R9", "old value", rdDataA, 32'h5555_0001);
    step("R9");

    // R7 / R8: masked flag updates
    idle(); flagWrEn = 1; flagMask = 5'h1F; flagData = 5'h15; step("R8");
    flagMask = 5'h03; flagData = 5'h0A; step("R8");
    idle(); step("R7");
    chk("R7", "flags X.Z.V", {24'd0, ccr}, 32'h0000_0016);
    flagWrEn = 1; flagMask = 5'h10; flagData = 5'h00; step("R8");
    idle(); step("R7");

    // R1: mixed traffic on all ports
    for (int n = 0; n < 3000; n++) begin
      supervisor  = 1'($urandom);
      rdSelA      = 4'($urandom);
      rdSelB      = 4'($urandom);
      wrEn        = 1'($urandom);
      wrSel       = 4'($urandom);
      wrSize      = 2'($urandom);
      wrData      = $urandom;
      altSpWrEn   = (($urandom % 8) == 0);
      altSpWrData = $urandom;
      flagWrEn    = 1'($urandom);
      flagMask    = 5'($urandom);
      flagData    = 5'($urandom);
      step("R1");
    end
    idle(); step("R1");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule